// File: doc/BRIEF.md
# Prefetch-Aware Cache Way Allocator

This block chooses which way of a 16-way set-associative data cache receives a new line after a miss. Each request carries three things: the set number, the valid bits of that set's ways, and the kind of access that missed. The kind is either a demand access or one of four prefetch hints: non-temporal, T0, T1 and T2. A 64-bit lockout register holds a separate 16-bit way mask for each prefetch hint. The masks keep prefetched data out of chosen parts of the cache. When a hint's mask forbids every way, prefetches of that hint are refused.

The selector picks among the ways that are allowed. It takes an invalid way first. When every allowed way is valid, it uses a round-robin pointer kept for each of the 64 sets. The result comes out as a one-hot vector and a 4-bit index. A no-allocate flag is raised when nothing may be chosen.

Requests arrive as a valid-only stream. There is no ready signal and no back-pressure: a request may be issued in every cycle. The result is present for exactly the one cycle in which `res_valid` is high, and the consumer must take it in that cycle. Tag lookup, data storage and line fill are handled elsewhere.

Top module: `way_victim_sel`

## Requirements
- R1: The access kind is coded on `req_kind` as 0 = demand, 1 = non-temporal, 2 = T0, 3 = T1, 4 = T2. The lockout register puts the T2 mask in bits [63:48], the T1 mask in [47:32], the T0 mask in [31:16] and the non-temporal mask in [15:0]. Bit n of a mask stands for way n.
- R2: On a prefetch request, a way whose bit is set in that hint's mask is never chosen.
- R3: When every way allowed for the request is excluded, `res_noalloc` is 1, `res_way_onehot` is 0 and `res_way_idx` is 0.
- R4: After reset, every mask is zero and every set's pointer is zero.
- R5: Demand requests ignore all lockout masks and always receive a way.
- R6: If any allowed way is invalid, the lowest-numbered allowed invalid way is chosen, and the set's pointer does not change.
- R7: If all allowed ways are valid, the chosen way is the first allowed way found when searching upward from the set's pointer, wrapping from 15 to 0. The pointer then becomes the chosen index plus one, modulo 16.
- R8: `res_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. The one-hot vector has the bit set that `res_way_idx` names.
- R9: A lockout write made in the same cycle as a request does not affect that request. It takes effect from the following cycle.
- R10: Each set has its own pointer. A round-robin choice in one set leaves the pointers of all other sets unchanged.
- R11: Kind codes 5, 6 and 7 are handled as demand accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_wr_en | input | 1 | Load the lockout register |
| lock_wr_data | input | 64 | New lockout register value |
| req_valid | input | 1 | Allocation request strobe |
| req_kind | input | 3 | Access kind code |
| req_set | input | 6 | Set number |
| req_way_valid | input | 16 | Valid bits of the set's ways |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_noalloc | output | 1 | No way may be allocated |
| res_way_onehot | output | 16 | Chosen way, one-hot |
| res_way_idx | output | 4 | Chosen way, binary index |

## Verification
Two kinds of event can land in the same clock edge. The first is a lockout write together with a request. The bench provokes it by issuing a write that locks every way for a hint in the same cycle as a request of that hint. That request must still get a way under the old mask, and an identical request one cycle later must be refused.

The second is a pointer advance in one cycle followed directly by a request to the same set. The bench sends back-to-back requests to one fully valid set, so that each result depends on the advance made by the one before. It also interleaves requests to other sets to show that the pointers are independent.

Every result is compared with a bench model of the masks, the pointers and the selection order.

// File: rtl/way_alloc_pkg.sv
package way_alloc_pkg;
  typedef enum logic [2:0] {
    KIND_DEMAND = 3'd0,
    KIND_NTA    = 3'd1,
    KIND_T0     = 3'd2,
    KIND_T1     = 3'd3,
    KIND_T2     = 3'd4
  } acc_kind_e;

  localparam int unsigned NUM_HINTS = 4;

  // Lane number of a prefetch kind inside the lockout register; -1 for demand.
  function automatic int hint_lane(input logic [2:0] kind);
    case (kind)
      KIND_NTA: return 0;
      KIND_T0:  return 1;
      KIND_T1:  return 2;
      KIND_T2:  return 3;
      default:  return -1;
    endcase
  endfunction
endpackage

// File: rtl/lockout_bank.sv
module lockout_bank
  import way_alloc_pkg::*;
#(
  parameter int unsigned WAYS  = 16,
  parameter int unsigned HINTS = NUM_HINTS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [WAYS*HINTS-1:0]   wr_data,
  input  logic [2:0]              kind,
  output logic [WAYS-1:0]         lane_mask
);
  logic [WAYS-1:0] lane_q [HINTS];

  for (genvar h = 0; h < HINTS; h++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)     lane_q[h] <= '0;
      else if (wr_en) lane_q[h] <= wr_data[h*WAYS +: WAYS];
    end
  end

  always_comb begin
    lane_mask = '0;
    for (int h = 0; h < int'(HINTS); h++)
      if (hint_lane(kind) == h) lane_mask = lane_q[h];
  end
endmodule

// File: rtl/rr_ptr_table.sv
module rr_ptr_table #(
  parameter int unsigned SETS = 64,
  parameter int unsigned IDXW = 4,
  localparam int unsigned SETW = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SETW-1:0] rd_set,
  output logic [IDXW-1:0] rd_ptr,
  input  logic            upd_en,
  input  logic [SETW-1:0] upd_set,
  input  logic [IDXW-1:0] upd_val
);
  logic [IDXW-1:0] ptr_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n)                                ptr_q[s] <= '0;
      else if (upd_en && upd_set == SETW'(s))   ptr_q[s] <= upd_val;
    end
  end

  assign rd_ptr = ptr_q[rd_set];
endmodule

// File: rtl/victim_pick.sv
module victim_pick #(
  parameter int unsigned WAYS = 16,
  localparam int unsigned IDXW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] lock_mask,
  input  logic [WAYS-1:0] way_valid,
  input  logic [IDXW-1:0] rr_ptr,
  output logic            none,
  output logic            use_rr,
  output logic [IDXW-1:0] pick,
  output logic [WAYS-1:0] onehot
);
  logic [WAYS-1:0] allowed;
  logic [WAYS-1:0] free_ways;
  logic [IDXW-1:0] probe;
  logic            found;

  always_comb begin
    allowed   = ~lock_mask;
    free_ways = allowed & ~way_valid;
    found     = 1'b0;
    use_rr    = 1'b0;
    pick      = '0;
    probe     = '0;
    for (int i = 0; i < int'(WAYS); i++) begin
      if (!found && free_ways[i]) begin
        found = 1'b1;
        pick  = IDXW'(i);
      end
    end
    for (int i = 0; i < int'(WAYS); i++) begin
      probe = rr_ptr + IDXW'(i);
      if (!found && allowed[probe]) begin
        found  = 1'b1;
        use_rr = 1'b1;
        pick   = probe;
      end
    end
    none   = !found;
    onehot = found ? (WAYS'(1) << pick) : '0;
  end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
  import way_alloc_pkg::*;
#(
  parameter int unsigned WAYS = 16,
  parameter int unsigned SETS = 64,
  localparam int unsigned IDXW = $clog2(WAYS),
  localparam int unsigned SETW = $clog2(SETS),
  localparam int unsigned LOCKW = WAYS * NUM_HINTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_wr_en,
  input  logic [LOCKW-1:0] lock_wr_data,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic [SETW-1:0]  req_set,
  input  logic [WAYS-1:0]  req_way_valid,
  output logic             res_valid,
  output logic             res_noalloc,
  output logic [WAYS-1:0]  res_way_onehot,
  output logic [IDXW-1:0]  res_way_idx
);
  logic [WAYS-1:0] lane_mask;
  logic [IDXW-1:0] cur_ptr;
  logic            sel_none, sel_rr;
  logic [IDXW-1:0] sel_idx;
  logic [WAYS-1:0] sel_onehot;
  logic            ptr_upd;

  lockout_bank #(.WAYS(WAYS), .HINTS(NUM_HINTS)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(lock_wr_en), .wr_data(lock_wr_data),
    .kind(req_kind), .lane_mask(lane_mask)
  );

  rr_ptr_table #(.SETS(SETS), .IDXW(IDXW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .rd_set(req_set), .rd_ptr(cur_ptr),
    .upd_en(ptr_upd), .upd_set(req_set), .upd_val(sel_idx + IDXW'(1))
  );

  victim_pick #(.WAYS(WAYS)) u_pick (
    .lock_mask(lane_mask), .way_valid(req_way_valid), .rr_ptr(cur_ptr),
    .none(sel_none), .use_rr(sel_rr), .pick(sel_idx), .onehot(sel_onehot)
  );

  assign ptr_upd = req_valid && sel_rr && !sel_none;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_noalloc    <= 1'b0;
      res_way_onehot <= '0;
      res_way_idx    <= '0;
    end else begin
      res_valid      <= req_valid;
      res_noalloc    <= req_valid && sel_none;
      res_way_onehot <= req_valid ? sel_onehot : '0;
      res_way_idx    <= (req_valid && !sel_none) ? sel_idx : '0;
    end
  end
endmodule

// File: rtl/way_victim_sel_chk.sv
module way_victim_sel_chk #(
  parameter int unsigned WAYS = 16,
  localparam int unsigned IDXW = $clog2(WAYS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [2:0]      req_kind,
  input logic [WAYS-1:0] req_way_valid,
  input logic [WAYS-1:0] lane_mask,
  input logic            res_valid,
  input logic            res_noalloc,
  input logic [WAYS-1:0] res_way_onehot,
  input logic [IDXW-1:0] res_way_idx
);
  logic is_demand;
  assign is_demand = (req_kind == 3'd0) || (req_kind > 3'd4);

  a_r8_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  a_r8_idx_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_noalloc) |-> (res_way_onehot[res_way_idx] && $onehot0(res_way_onehot)));
  a_r3_noalloc_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_noalloc) |-> (res_way_onehot == '0 && res_way_idx == '0));
  a_r2_locked_avoided: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_demand) |=> (res_noalloc || (res_way_onehot & $past(lane_mask)) == '0));
  a_r5_demand_allocates: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_demand) |=> !res_noalloc);
  a_r6_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_demand && req_way_valid != '1) |=> ((res_way_onehot & $past(req_way_valid)) == '0));
endmodule

bind way_victim_sel way_victim_sel_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_way_valid(req_way_valid), .lane_mask(lane_mask), .res_valid(res_valid),
  .res_noalloc(res_noalloc), .res_way_onehot(res_way_onehot), .res_way_idx(res_way_idx)
);

// File: tb/way_victim_sel_bench.sv
`timescale 1ns/1ps
module way_victim_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock_wr_en = 1'b0;
  logic [63:0] lock_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [5:0]  req_set = '0;
  logic [15:0] req_way_valid = '0;
  logic        res_valid, res_noalloc;
  logic [15:0] res_way_onehot;
  logic [3:0]  res_way_idx;

  int n_checks = 0;
  int n_fail = 0;

  logic [63:0] m_lock = '0;
  logic [3:0]  m_ptr [64];

  bit          pend = 0;
  logic        e_na;
  logic [15:0] e_oh;
  logic [3:0]  e_idx;
  string       e_tag = "";

  always #2.5 clk = ~clk;

  way_victim_sel u_way_victim_sel (
    .clk(clk), .rst_n(rst_n), .lock_wr_en(lock_wr_en), .lock_wr_data(lock_wr_data),
    .req_valid(req_valid), .req_kind(req_kind), .req_set(req_set),
    .req_way_valid(req_way_valid), .res_valid(res_valid), .res_noalloc(res_noalloc),
    .res_way_onehot(res_way_onehot), .res_way_idx(res_way_idx)
  );

  function automatic logic [15:0] lane_of(input logic [2:0] k, input logic [63:0] lk);
    case (k)
      3'd1: return lk[15:0];
      3'd2: return lk[31:16];
      3'd3: return lk[47:32];
      3'd4: return lk[63:48];
      default: return 16'h0;
    endcase
  endfunction

  // Model of one selection; returns the requirement the path exercises.
  function automatic string model(input logic [2:0] k, input logic [15:0] v, input logic [3:0] p,
                                  input logic [63:0] lk, output logic na, output logic [15:0] oh,
                                  output logic [3:0] idx, output bit rr);
    logic [15:0] al;
    logic [3:0]  j;
    al = ~lane_of(k, lk);
    na = 1; oh = '0; idx = '0; rr = 0;
    for (int i = 0; i < 16; i++)
      if (na && al[i] && !v[i]) begin na = 0; idx = 4'(i); end
    if (!na) begin oh = 16'(1) << idx; return ((k == 0 || k > 4) ? "R5" : "R6"); end
    for (int i = 0; i < 16; i++) begin
      j = p + 4'(i);
      if (na && al[j]) begin na = 0; idx = j; rr = 1; end
    end
    if (na) return "R3";
    oh = 16'(1) << idx;
    return "R7";
  endfunction

  task automatic check_prev();
    n_checks++;
    if (pend) begin
      if (res_valid !== 1'b1 || res_noalloc !== e_na || res_way_onehot !== e_oh || res_way_idx !== e_idx) begin
        n_fail++;
        $display("FAIL %s: got v=%b na=%b oh=%h idx=%0d, expected v=1 na=%b oh=%h idx=%0d",
                 e_tag, res_valid, res_noalloc, res_way_onehot, res_way_idx, e_na, e_oh, e_idx);
      end
    end else if (res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R8: got res_valid=%b, expected 0", res_valid);
    end
  endtask

  // Runs at a negative edge: check the last result, drive new inputs, advance the model.
  task automatic step(input bit rq, input logic [2:0] k, input logic [5:0] s, input logic [15:0] v,
                      input bit wr, input logic [63:0] wd, input string tag);
    logic na; logic [15:0] oh; logic [3:0] idx; bit rr; string t;
    @(negedge clk);
    check_prev();
    req_valid = rq; req_kind = k; req_set = s; req_way_valid = v;
    lock_wr_en = wr; lock_wr_data = wd;
    pend = rq;
    if (rq) begin
      t = model(k, v, m_ptr[s], m_lock, na, oh, idx, rr);
      e_na = na; e_oh = oh; e_idx = idx;
      e_tag = (tag == "") ? t : tag;
      if (rr) m_ptr[s] = idx + 4'd1;
    end
    if (wr) m_lock = wd;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    logic [63:0] wd;
    for (int s = 0; s < 64; s++) m_ptr[s] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (res_valid !== 0 || res_way_onehot !== 0) begin
      n_fail++;
      $display("FAIL R4: got v=%b oh=%h during reset, expected 0/0000", res_valid, res_way_onehot);
    end
    rst_n = 1'b1;
    // R4: masks and pointers clear after reset
    step(1, 3'd4, 6'd5, 16'hFFFF, 0, 0, "R4");
    step(1, 3'd1, 6'd6, 16'hFFFF, 0, 0, "R4");
    // R1: one way allowed per lane, each lane different
    wd = {~16'h0010, ~16'h0008, ~16'h0004, ~16'h0002};
    step(0, 0, 0, 0, 1, wd, "");
    step(1, 3'd1, 6'd10, 16'hFFFF, 0, 0, "R1");
    step(1, 3'd2, 6'd10, 16'hFFFF, 0, 0, "R1");
    step(1, 3'd3, 6'd10, 16'hFFFF, 0, 0, "R1");
    step(1, 3'd4, 6'd10, 16'hFFFF, 0, 0, "R1");
    // R2: T1 blocks ways 0..7; invalid ways 3 and 9
    step(0, 0, 0, 0, 1, 64'h0000_00FF_0000_0000, "");
    step(1, 3'd3, 6'd11, ~16'h0208, 0, 0, "R2");
    // R3: T2 fully locked; R5 demand ignores; R11 code 6 as demand
    step(0, 0, 0, 0, 1, 64'hFFFF_0000_0000_0000, "");
    step(1, 3'd4, 6'd12, 16'h0000, 0, 0, "R3");
    step(1, 3'd0, 6'd12, 16'hFFFF, 0, 0, "R5");
    step(1, 3'd6, 6'd12, 16'hFFFF, 0, 0, "R11");
    step(1, 3'd7, 6'd12, 16'hF0FF, 0, 0, "R11");
    // R9: lock T0 fully in the same cycle as a T0 request
    step(1, 3'd2, 6'd13, 16'hFFFF, 1, 64'h0000_0000_FFFF_0000, "R9");
    step(1, 3'd2, 6'd13, 16'hFFFF, 0, 0, "R9");
    // R7 back-to-back on one set; R10 other set untouched
    step(1, 3'd0, 6'd20, 16'hFFFF, 0, 0, "R7");
    step(1, 3'd0, 6'd20, 16'hFFFF, 0, 0, "R7");
    step(1, 3'd0, 6'd21, 16'hFFFF, 0, 0, "R10");
    step(1, 3'd0, 6'd20, 16'hFFFF, 0, 0, "R7");
    step(1, 3'd0, 6'd20, 16'hFFDF, 0, 0, "R6");
    step(1, 3'd0, 6'd20, 16'hFFFF, 0, 0, "R6");
    // random traffic
    for (int n = 0; n < 400; n++) begin
      bit wr = ($urandom % 10) == 0;
      logic [63:0] rd = {$urandom, $urandom};
      logic [63:0] wv = rd & {$urandom, $urandom};
      if (($urandom % 4) == 0) wv[16*($urandom % 4) +: 16] = 16'hFFFF;
      step(($urandom % 5) != 0, 3'($urandom % 8), 6'($urandom % 4),
           (($urandom % 3) == 0) ? 16'($urandom) : 16'hFFFF, wr, wv, "");
    end
    step(0, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, 0, "R8");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule